// File: doc/BRIEF.md
# Completion Timeout Tracker

This block follows non-posted requests from the moment they are issued until their completion returns. It does this for up to a parameterised number of tags. Each tag has a valid flag and an age counter that advances on a one-microsecond timebase strobe. When a tag's age reaches the limit chosen by a 4-bit programmable code, the block retires that tag. It then raises a one-cycle timeout event that carries the tag number.

The code selects one of six fixed limits, which range from tens of microseconds to more than a second. The limits come in groups. Every code outside the defined set falls back to the default limit. The limit is looked up from the current code on every cycle, so a new code applies at once to requests already in flight. A disable input stops all timeout events. When the disable input is released, every outstanding age restarts from zero. A live count of outstanding tags is also provided.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: Immediately after reset, `tmo_event` is 0 and `pending_cnt` is 0.
- R2: The limit in ticks is selected by `tmo_code` as follows:
  - 4'b0001 selects `LIM_SHORT` (default 95).
  - 4'b0010 selects `LIM_MID` (default 9500).
  - 4'b0101 selects `LIM_DEF` (default 45000).
  - 4'b0110 selects `LIM_LONG` (default 165000).
  - 4'b1001 selects `LIM_XLONG` (default 450000).
  - 4'b1010 selects `LIM_MAX` (default 1650000).
  - 4'b0000 and every other code select `LIM_DEF`.
- R3: A tag's age starts at 0 on the edge that captures its request. The age rises by one on each later edge where `us_tick` is 1. The timeout event is registered on the edge after the age first equals the limit. With a tick on every P-th cycle, the event is therefore seen P*L+1 cycles after the request edge.
- R4: A completion for an outstanding tag retires it. `pending_cnt` drops by one, and that tag never times out afterwards.
- R5: A completion for a tag that is not outstanding changes neither `pending_cnt` nor any age.
- R6: A request and a completion for different tags in the same cycle are both applied.
- R7: While `tmo_disable` is 1, no timeout event is raised, even when ages pass the limit.
- R8: On the first edge where `tmo_disable` is seen 0 after being 1, all ages reset to 0. Timing then restarts, so the event is seen L+2 cycles after the release with a tick on every cycle.
- R9: A change of `tmo_code` applies the new limit to existing ages. If a tag's age already meets the new limit, its event is raised on the next edge.
- R10: A timeout drives `tmo_event` high for one cycle with the tag on `tmo_tag`, and it retires that tag. When several tags expire together, they are reported one per cycle with the lowest tag first.
- R11: `pending_cnt` equals the number of outstanding tags. A request for a tag that is already outstanding restarts its age without counting it twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request issued strobe |
| req_tag | input | TAG_W | Tag of issued request |
| cpl_valid | input | 1 | Completion received strobe |
| cpl_tag | input | TAG_W | Tag of received completion |
| tmo_code | input | 4 | Timeout value code |
| tmo_disable | input | 1 | Suppresses timeout detection when 1 |
| us_tick | input | 1 | One-microsecond timebase strobe |
| tmo_event | output | 1 | One-cycle timeout strobe |
| tmo_tag | output | TAG_W | Tag that timed out |
| pending_cnt | output | CNT_W | Number of outstanding tags |

## Verification
The hardest situations to reach from the ports are a limit being crossed because the code changed rather than because a tick arrived, and several tags reaching their limit on the same edge. The bench builds the first case by aging a tag under a long code and then switching to a short code mid-flight. It builds the second by issuing several tags while the timebase is held low, so that they share an age, and then releasing the ticks. Shrunken limit parameters let every code be swept to expiry in a few cycles.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
   localparam logic [3:0] CODE_DEFAULT = 4'b0000;
   localparam logic [3:0] CODE_SHORT   = 4'b0001;
   localparam logic [3:0] CODE_MID     = 4'b0010;
   localparam logic [3:0] CODE_DEF_B   = 4'b0101;
   localparam logic [3:0] CODE_LONG    = 4'b0110;
   localparam logic [3:0] CODE_XLONG   = 4'b1001;
   localparam logic [3:0] CODE_MAX     = 4'b1010;

   function automatic int unsigned max_of6(
      input int unsigned a, input int unsigned b, input int unsigned c,
      input int unsigned d, input int unsigned e, input int unsigned f);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      if (f > m) m = f;
      return m;
   endfunction
endpackage

// File: rtl/ctt_limit_map.sv
module ctt_limit_map
   import ctt_pkg::*;
#(
   parameter int unsigned AGE_W     = 21,
   parameter int unsigned LIM_SHORT = 95,
   parameter int unsigned LIM_MID   = 9500,
   parameter int unsigned LIM_DEF   = 45000,
   parameter int unsigned LIM_LONG  = 165000,
   parameter int unsigned LIM_XLONG = 450000,
   parameter int unsigned LIM_MAX   = 1650000
) (
   input  logic [3:0]       code,
   output logic [AGE_W-1:0] limit
);
   always_comb begin
      unique case (code)
         CODE_SHORT: limit = AGE_W'(LIM_SHORT);
         CODE_MID:   limit = AGE_W'(LIM_MID);
         CODE_LONG:  limit = AGE_W'(LIM_LONG);
         CODE_XLONG: limit = AGE_W'(LIM_XLONG);
         CODE_MAX:   limit = AGE_W'(LIM_MAX);
         default:    limit = AGE_W'(LIM_DEF); // R2: default and reserved codes
      endcase
   end
endmodule

// File: rtl/ctt_tag_slot.sv
module ctt_tag_slot #(
   parameter int unsigned AGE_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             arm,
   input  logic             drop,
   input  logic             restart,
   input  logic [AGE_W-1:0] limit,
   output logic             valid,
   output logic             at_limit
);
   localparam logic [AGE_W-1:0] AGE_SAT = '1;

   logic [AGE_W-1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         age   <= '0;
      end else if (arm) begin
         valid <= 1'b1;
         age   <= '0;
      end else begin
         if (drop) valid <= 1'b0;
         if (restart) age <= '0;
         else if (valid && tick && age != AGE_SAT) age <= age + 1'b1;
      end
   end

   assign at_limit = valid && (age >= limit);

   assert_arm_clears_age_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm) |-> (valid && age == '0));

   assert_age_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(valid) && !$past(arm) && !$past(restart)) |-> (age >= $past(age)));
endmodule

// File: rtl/ctt_expiry_arb.sv
module ctt_expiry_arb #(
   parameter int unsigned NUM_TAGS = 32,
   parameter int unsigned TAG_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAGS-1:0] cand,
   output logic [NUM_TAGS-1:0] gnt,
   output logic [TAG_W-1:0]    idx,
   output logic                any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = NUM_TAGS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            idx = TAG_W'(i);
            any = 1'b1;
         end
      end
      gnt = '0;
      if (any) gnt[idx] = 1'b1;
   end

   assert_grant_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~cand) == '0));
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker
   import ctt_pkg::*;
#(
   parameter int unsigned NUM_TAGS  = 32,
   parameter int unsigned AGE_W     = 21,
   parameter int unsigned LIM_SHORT = 95,
   parameter int unsigned LIM_MID   = 9500,
   parameter int unsigned LIM_DEF   = 45000,
   parameter int unsigned LIM_LONG  = 165000,
   parameter int unsigned LIM_XLONG = 450000,
   parameter int unsigned LIM_MAX   = 1650000,
   localparam int unsigned TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
   localparam int unsigned CNT_W    = $clog2(NUM_TAGS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             cpl_valid,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic [3:0]       tmo_code,
   input  logic             tmo_disable,
   input  logic             us_tick,
   output logic             tmo_event,
   output logic [TAG_W-1:0] tmo_tag,
   output logic [CNT_W-1:0] pending_cnt
);
   localparam int unsigned LIM_TOP =
      max_of6(LIM_SHORT, LIM_MID, LIM_DEF, LIM_LONG, LIM_XLONG, LIM_MAX);

   initial begin : param_check
      if (NUM_TAGS < 2) $error("NUM_TAGS must be at least 2");
      if (AGE_W < 2 || AGE_W > 31) $error("AGE_W out of range");
      if (LIM_TOP >= (1 << AGE_W)) $error("AGE_W too narrow for largest limit");
   end

   logic [AGE_W-1:0]    limit;
   logic                dis_q;
   logic                restart;
   logic                exp_en;
   logic [NUM_TAGS-1:0] req_hit, cpl_hit, drop, valid_vec, at_lim, cand, gnt;
   logic [TAG_W-1:0]    pick_idx;
   logic                pick_any;

   ctt_limit_map #(
      .AGE_W(AGE_W), .LIM_SHORT(LIM_SHORT), .LIM_MID(LIM_MID), .LIM_DEF(LIM_DEF),
      .LIM_LONG(LIM_LONG), .LIM_XLONG(LIM_XLONG), .LIM_MAX(LIM_MAX)
   ) u_map (
      .code  (tmo_code),
      .limit (limit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) dis_q <= 1'b0;
      else        dis_q <= tmo_disable;
   end

   assign restart = dis_q & ~tmo_disable;
   assign exp_en  = ~dis_q & ~tmo_disable;

   for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
      assign req_hit[g] = req_valid && (req_tag == TAG_W'(g));
      assign cpl_hit[g] = cpl_valid && (cpl_tag == TAG_W'(g));
      assign drop[g]    = cpl_hit[g] | gnt[g];
      assign cand[g]    = at_lim[g] & exp_en & ~req_hit[g] & ~cpl_hit[g];

      ctt_tag_slot #(.AGE_W(AGE_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (us_tick),
         .arm      (req_hit[g]),
         .drop     (drop[g]),
         .restart  (restart),
         .limit    (limit),
         .valid    (valid_vec[g]),
         .at_limit (at_lim[g])
      );
   end

   ctt_expiry_arb #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (cand),
      .gnt   (gnt),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_event <= 1'b0;
         tmo_tag   <= '0;
      end else begin
         tmo_event <= pick_any;
         tmo_tag   <= pick_idx;
      end
   end

   assign pending_cnt = CNT_W'($countones(valid_vec));

   assert_quiet_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_event |-> !$past(tmo_disable));

   assert_event_retires_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_event |-> !valid_vec[tmo_tag]);

   assert_no_repeat_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_event |=> (!tmo_event || tmo_tag != $past(tmo_tag)));

   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pending_cnt <= CNT_W'(NUM_TAGS));
endmodule

// File: tb/cpl_timeout_tracker_bench.sv
module cpl_timeout_tracker_bench;
   localparam int NT = 32;
   localparam int TW = 5;
   localparam int CW = 6;
   localparam int L_SHORT = 4, L_MID = 7, L_DEF = 10, L_LONG = 13, L_XLONG = 16, L_MAX = 19;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, cpl_valid = 0, tmo_disable = 0, us_tick = 0;
   logic [TW-1:0] req_tag = '0, cpl_tag = '0;
   logic [3:0] tmo_code = 4'b0000;
   logic tmo_event;
   logic [TW-1:0] tmo_tag;
   logic [CW-1:0] pending_cnt;
   int tests = 0, fails = 0;

   always #10 clk = ~clk;

   cpl_timeout_tracker #(
      .NUM_TAGS(NT), .AGE_W(5), .LIM_SHORT(L_SHORT), .LIM_MID(L_MID), .LIM_DEF(L_DEF),
      .LIM_LONG(L_LONG), .LIM_XLONG(L_XLONG), .LIM_MAX(L_MAX)
   ) u_cpl_timeout_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .tmo_code(tmo_code),
      .tmo_disable(tmo_disable), .us_tick(us_tick), .tmo_event(tmo_event),
      .tmo_tag(tmo_tag), .pending_cnt(pending_cnt)
   );

   function automatic int exp_lim(input logic [3:0] c);
      case (c)
         4'b0001: return L_SHORT;
         4'b0010: return L_MID;
         4'b0110: return L_LONG;
         4'b1001: return L_XLONG;
         4'b1010: return L_MAX;
         default: return L_DEF;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic issue(input int t);
      req_valid = 1; req_tag = TW'(t);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic run_to_evt(input int p, output int n);
      n = 0;
      while (n < 400) begin
         us_tick = ((n + 1) % p == 0);
         @(negedge clk);
         n++;
         if (tmo_event) break;
      end
      us_tick = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int n, quiet;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 event after reset", tmo_event, 0);
      check("R1 count after reset", pending_cnt, 0);

      // R2 / R3: every code, one tick per cycle
      for (int c = 0; c < 16; c++) begin
         tmo_code = 4'(c);
         issue((c * 2 + 1) % NT);
         run_to_evt(1, n);
         check($sformatf("R2 code %0d cycles", c), n, exp_lim(4'(c)) + 1);
         check($sformatf("R10 code %0d tag", c), tmo_tag, (c * 2 + 1) % NT);
         check("R10 count after timeout", pending_cnt, 0);
         @(negedge clk);
         check("R10 single-cycle strobe", tmo_event, 0);
      end

      // R3: sparse ticks
      for (int p = 2; p <= 4; p++) begin
         tmo_code = 4'b0001;
         issue(12);
         run_to_evt(p, n);
         check($sformatf("R3 tick period %0d", p), n, p * L_SHORT + 1);
         @(negedge clk);
      end

      // R4: completion before limit
      tmo_code = 4'b0001;
      issue(9);
      us_tick = 1; repeat (2) @(negedge clk);
      cpl_valid = 1; cpl_tag = 5'd9; @(negedge clk); cpl_valid = 0;
      check("R4 count after completion", pending_cnt, 0);
      quiet = 0;
      repeat (30) begin @(negedge clk); if (tmo_event) quiet++; end
      us_tick = 0;
      check("R4 no event after completion", quiet, 0);

      // R5: stray completion
      issue(1);
      cpl_valid = 1; cpl_tag = 5'd20; @(negedge clk); cpl_valid = 0;
      check("R5 stray completion count", pending_cnt, 1);
      run_to_evt(1, n);
      check("R5 timing unaffected", n, L_SHORT + 1);
      check("R5 tag", tmo_tag, 1);
      @(negedge clk);

      // R6: request and completion together
      issue(1);
      req_valid = 1; req_tag = 5'd4; cpl_valid = 1; cpl_tag = 5'd1;
      @(negedge clk);
      req_valid = 0; cpl_valid = 0;
      check("R6 count after simultaneous", pending_cnt, 1);
      run_to_evt(1, n);
      check("R6 new tag times out", n, L_SHORT + 1);
      check("R6 tag", tmo_tag, 4);
      @(negedge clk);

      // R11: re-request restarts age
      issue(6);
      us_tick = 1; repeat (3) @(negedge clk); us_tick = 0;
      issue(6);
      check("R11 no double count", pending_cnt, 1);
      run_to_evt(1, n);
      check("R11 restart on re-request", n, L_SHORT + 1);
      @(negedge clk);

      // R10: simultaneous expiry, lowest first
      issue(5);
      issue(2);
      check("R11 two outstanding", pending_cnt, 2);
      run_to_evt(1, n);
      check("R10 shared expiry cycle", n, L_SHORT + 1);
      check("R10 first tag lowest", tmo_tag, 2);
      @(negedge clk);
      check("R10 second event", tmo_event, 1);
      check("R10 second tag", tmo_tag, 5);
      @(negedge clk);
      check("R10 strobe ends", tmo_event, 0);
      check("R10 count drained", pending_cnt, 0);

      // R9: code change applies to aged request
      tmo_code = 4'b0110;
      issue(3);
      us_tick = 1; quiet = 0;
      repeat (8) begin @(negedge clk); if (tmo_event) quiet++; end
      check("R9 no event under long code", quiet, 0);
      tmo_code = 4'b0001;
      @(negedge clk);
      us_tick = 0;
      check("R9 event after shortening", tmo_event, 1);
      check("R9 tag", tmo_tag, 3);
      @(negedge clk);

      // R7 / R8: disable and release
      tmo_code = 4'b0000;
      tmo_disable = 1;
      issue(7);
      us_tick = 1; quiet = 0;
      repeat (40) begin @(negedge clk); if (tmo_event) quiet++; end
      us_tick = 0;
      check("R7 no event while disabled", quiet, 0);
      check("R7 tag still outstanding", pending_cnt, 1);
      tmo_disable = 0;
      run_to_evt(1, n);
      check("R8 restart on release", n, L_DEF + 2);
      check("R8 tag", tmo_tag, 7);
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule